// File: doc/BRIEF.md
# USB Line State and Bus Speed Detector

This block watches the D+ and D- wires of a full-speed or low-speed USB link and tells a downstream packet receiver two things: which signalling rate is active, and when the bus has seen a bus reset or a low-speed keep-alive. Both wires are first brought into the local clock domain through two-flop synchronizers. Each synchronized sample is then sorted into one of four line symbols: single-ended zero, single-ended one, a full-speed idle level or a low-speed idle level.

Every stretch of single-ended zero is timed in cycles of the sampling clock. When the stretch ends, its length decides whether it was a bus reset (longer than `RESET_CYCLES`), a keep-alive (low speed only, longer than `KEEPALIVE_CYCLES` but not longer than `RESET_CYCLES`) or an ordinary end of packet. The idle polarity that follows the zero decides the speed. A reset returns the speed to what the configuration selects. The configuration input either lets the block detect the speed from polarity, or pins the speed to full or to low whatever the wires show.

Top module: `usb_line_speed_det`

## Requirements
- R1: The synchronized pair {dp_i, dm_i} is read as 2'b00 single-ended zero, 2'b11 single-ended one, 2'b10 full-speed idle and 2'b01 low-speed idle. Each wire passes through two flops before it is read.
- R2: When a zero that lasted more than RESET_CYCLES cycles ends, bus_reset_o pulses once and the speed returns to the configured mode: low for forced low, full for forced full, and full in automatic mode unless the ending level is an idle level.
- R3: When a zero ends while speed_low_o is 1, and the zero lasted more than KEEPALIVE_CYCLES cycles but no more than RESET_CYCLES cycles, keep_alive_o pulses once.
- R4: A zero that ends while speed_low_o is 0 never raises keep_alive_o, whatever its length up to RESET_CYCLES.
- R5: In automatic mode (mode_i 2'b00 or 2'b11), a zero that ends on the full-speed idle level sets speed_low_o to 0 and one that ends on the low-speed idle level sets it to 1. An ending single-ended one leaves the speed unchanged, except that after a reset it gives full speed.
- R6: With mode_i 2'b01 (forced full) or 2'b10 (forced low), every zero end sets speed_low_o to 0 or 1 respectively, and the ending polarity has no effect.
- R7: speed_low_o changes only when a zero ends or at the first non-zero level after reset. Single-ended ones and mode_i changes in between leave it as it is.
- R8: bus_reset_o and keep_alive_o are one-cycle pulses, are never high together and appear only in the cycle after a zero ends.
- R9: After reset the block waits for the first non-zero level. Zero before it raises no event, however long it lasts, and that first level sets the speed as in R5 and R6.
- R10: While rst_n is low, both pulses are 0 and speed_low_o is 1 only if mode_i is 2'b10.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dp_i | input | 1 | D+ wire, asynchronous |
| dm_i | input | 1 | D- wire, asynchronous |
| mode_i | input | 2 | 00 automatic, 01 forced full, 10 forced low, 11 automatic |
| speed_low_o | output | 1 | 1 = low speed active, 0 = full speed |
| bus_reset_o | output | 1 | One-cycle pulse: long zero ended |
| keep_alive_o | output | 1 | One-cycle pulse: low-speed keep-alive ended |

## Verification
The assertions assume that mode_i is held steady across a zero and the cycle that ends it. They also assume the wires change no faster than the synchronizers can follow, so that every level lasts at least one sampling cycle. The bench changes mode_i only while the line is idle, well before the next zero. It holds each wire level for whole clock cycles and drives it at the falling edge. The stimulus covers zero lengths just below, at and just above both thresholds, under all speeds and modes.

// File: rtl/usb_ls_pkg.sv
// Shared types for the USB line state and speed detector.
// Assumes: {D+, D-} pair ordering as used at the top ports.
package usb_ls_pkg;

    typedef enum logic [1:0] {
        SYM_SE0 = 2'b00,
        SYM_LSJ = 2'b01,
        SYM_FSJ = 2'b10,
        SYM_SE1 = 2'b11
    } line_sym_e;

    typedef enum logic [1:0] {
        MODE_AUTO  = 2'b00,
        MODE_FULL  = 2'b01,
        MODE_LOW   = 2'b10,
        MODE_AUTO2 = 2'b11
    } speed_mode_e;

endpackage

// File: rtl/usb_ls_sync.sv
// Two-flop synchronizer bank for WIDTH asynchronous inputs.
// Assumes: inputs hold each level for at least one clk period.
module usb_ls_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // Shift the raw level through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/usb_ls_classify.sv
// Sorts the synchronized wire pair into one of four line symbols.
// Assumes: pair[1] is D+, pair[0] is D-.
module usb_ls_classify
    import usb_ls_pkg::*;
(
    input  logic [1:0] pair_i,
    output line_sym_e  sym_o
);
    // Map the pair straight onto the symbol encoding.
    always_comb begin
        unique case (pair_i)
            2'b00:   sym_o = SYM_SE0;
            2'b01:   sym_o = SYM_LSJ;
            2'b10:   sym_o = SYM_FSJ;
            default: sym_o = SYM_SE1;
        endcase
    end
endmodule

// File: rtl/usb_ls_se0_timer.sv
// Counts consecutive zero cycles, saturating one past the longest threshold.
// Assumes: the count is read in the first cycle after the zero ends.
module usb_ls_se0_timer #(
    parameter int SAT   = 121,
    localparam int CW   = $clog2(SAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_se0_i,
    output logic [CW-1:0] dur_o
);
    localparam logic [CW-1:0] SAT_V = CW'(SAT);

    // Count up during zero, hold at saturation, clear on any other level.
    always_ff @(posedge clk) begin
        if (!rst_n)            dur_o <= '0;
        else if (!is_se0_i)    dur_o <= '0;
        else if (dur_o != SAT_V) dur_o <= dur_o + 1'b1;
    end
endmodule

// File: rtl/usb_ls_speed_ctl.sv
// Decides events at each zero end and keeps the active speed register.
// Assumes: mode_i is steady across a zero and its end; dur_i counts the zero.
module usb_ls_speed_ctl
    import usb_ls_pkg::*;
#(
    parameter int RESET_CYCLES     = 120,
    parameter int KEEPALIVE_CYCLES = 58,
    parameter int CW               = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  line_sym_e     sym_i,
    input  logic [CW-1:0] dur_i,
    input  logic [1:0]    mode_i,
    output logic          speed_low_o,
    output logic          bus_reset_o,
    output logic          keep_alive_o
);
    localparam logic [CW-1:0] RST_LIM = CW'(RESET_CYCLES);
    localparam logic [CW-1:0] KA_LIM  = CW'(KEEPALIVE_CYCLES);

    logic init_q;
    logic was_se0_q;
    logic se0_end;
    logic long_zero;
    logic mid_zero;
    logic base_low;
    logic next_low;

    // Speed chosen by mode and ending level, falling back to base_low.
    function automatic logic pick_speed(input logic [1:0] mode,
                                        input line_sym_e sym,
                                        input logic base);
        if (mode == MODE_FULL)     return 1'b0;
        if (mode == MODE_LOW)      return 1'b1;
        if (sym == SYM_FSJ)        return 1'b0;
        if (sym == SYM_LSJ)        return 1'b1;
        return base;
    endfunction

    // Classify the ending zero and choose the next speed.
    always_comb begin
        se0_end   = was_se0_q && (sym_i != SYM_SE0) && !init_q;
        long_zero = dur_i > RST_LIM;
        mid_zero  = (dur_i > KA_LIM) && !long_zero;
        base_low  = long_zero ? (mode_i == MODE_LOW) : speed_low_o;
        next_low  = pick_speed(mode_i, sym_i, base_low);
    end

    // Register the init flag, the zero history, the speed and the pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q       <= 1'b1;
            was_se0_q    <= 1'b0;
            speed_low_o  <= (mode_i == MODE_LOW);
            bus_reset_o  <= 1'b0;
            keep_alive_o <= 1'b0;
        end else begin
            was_se0_q    <= (sym_i == SYM_SE0);
            bus_reset_o  <= 1'b0;
            keep_alive_o <= 1'b0;
            if (init_q) begin
                if (sym_i != SYM_SE0) begin
                    init_q      <= 1'b0;
                    speed_low_o <= pick_speed(mode_i, sym_i, speed_low_o);
                end
            end else if (se0_end) begin
                bus_reset_o  <= long_zero;
                keep_alive_o <= mid_zero && speed_low_o;
                speed_low_o  <= next_low;
            end
        end
    end
endmodule

// File: rtl/usb_line_speed_det.sv
// Top: synchronizes D+/D-, classifies the line, times zeros, tracks speed.
// Assumes: clk is the fixed sampling clock the thresholds are counted in.
module usb_line_speed_det
    import usb_ls_pkg::*;
#(
    parameter int RESET_CYCLES     = 120,
    parameter int KEEPALIVE_CYCLES = 58,
    parameter int SYNC_STAGES      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dp_i,
    input  logic       dm_i,
    input  logic [1:0] mode_i,
    output logic       speed_low_o,
    output logic       bus_reset_o,
    output logic       keep_alive_o
);
    localparam int SAT = RESET_CYCLES + 1;
    localparam int CW  = $clog2(SAT + 1);

    logic [1:0]    pair_sync;
    line_sym_e     cur_sym;
    logic [CW-1:0] se0_dur;

    usb_ls_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dp_i, dm_i}),
        .sync_o  (pair_sync)
    );

    usb_ls_classify classify_i (
        .pair_i (pair_sync),
        .sym_o  (cur_sym)
    );

    usb_ls_se0_timer #(.SAT(SAT)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_se0_i (cur_sym == SYM_SE0),
        .dur_o    (se0_dur)
    );

    usb_ls_speed_ctl #(
        .RESET_CYCLES     (RESET_CYCLES),
        .KEEPALIVE_CYCLES (KEEPALIVE_CYCLES),
        .CW               (CW)
    ) ctl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sym_i        (cur_sym),
        .dur_i        (se0_dur),
        .mode_i       (mode_i),
        .speed_low_o  (speed_low_o),
        .bus_reset_o  (bus_reset_o),
        .keep_alive_o (keep_alive_o)
    );
endmodule

// File: rtl/usb_line_speed_det_chk.sv
// Property checker for the detector, bound to the top module.
// Assumes: mode is steady across each zero end.
module usb_line_speed_det_chk
    import usb_ls_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input line_sym_e  cur_sym,
    input logic [1:0] mode_i,
    input logic       speed_low_o,
    input logic       bus_reset_o,
    input logic       keep_alive_o
);
    logic sym_zero_d;
    logic chk_init;
    logic zero_end;

    // Track the previous symbol and whether a non-zero level has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_zero_d <= 1'b0;
            chk_init   <= 1'b1;
        end else begin
            sym_zero_d <= (cur_sym == SYM_SE0);
            if (cur_sym != SYM_SE0) chk_init <= 1'b0;
        end
    end

    assign zero_end = sym_zero_d && (cur_sym != SYM_SE0);

    assert_pulses_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_reset_o && keep_alive_o));

    assert_reset_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_o |=> !bus_reset_o);

    assert_ka_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        keep_alive_o |=> !keep_alive_o);

    assert_event_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_o || keep_alive_o) |-> $past(zero_end));

    assert_speed_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(chk_init) && !$past(zero_end)) |-> $stable(speed_low_o));

    assert_ka_needs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        keep_alive_o |-> $past(speed_low_o));

    assert_forced_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_o && mode_i == MODE_FULL) |-> !speed_low_o);

    assert_forced_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_o && mode_i == MODE_LOW) |-> speed_low_o);
endmodule

bind usb_line_speed_det usb_line_speed_det_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cur_sym      (cur_sym),
    .mode_i       (mode_i),
    .speed_low_o  (speed_low_o),
    .bus_reset_o  (bus_reset_o),
    .keep_alive_o (keep_alive_o)
);

// File: tb/usb_line_speed_det_tb_top.sv
// Bench: vector table of zero segments, then directed reset/init/hold tests.
module usb_line_speed_det_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dp, dm;
    logic [1:0] mode;
    logic       speed_low, bus_reset, keep_alive;

    int n_checks = 0;
    int n_fail   = 0;
    int cnt_rst, cnt_ka;
    bit done = 0;

    always #10 clk = ~clk;

    usb_line_speed_det dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .dp_i         (dp),
        .dm_i         (dm),
        .mode_i       (mode),
        .speed_low_o  (speed_low),
        .bus_reset_o  (bus_reset),
        .keep_alive_o (keep_alive)
    );

    // {mode, zero length, ending {dp,dm}, exp reset, exp keep-alive, exp low}
    localparam int NV = 16;
    localparam logic [22:0] VEC [NV] = '{
        {2'd0, 16'd2,   2'b01, 1'b0, 1'b0, 1'b1},
        {2'd0, 16'd58,  2'b01, 1'b0, 1'b0, 1'b1},
        {2'd0, 16'd59,  2'b01, 1'b0, 1'b1, 1'b1},
        {2'd0, 16'd120, 2'b01, 1'b0, 1'b1, 1'b1},
        {2'd0, 16'd121, 2'b01, 1'b1, 1'b0, 1'b1},
        {2'd0, 16'd10,  2'b10, 1'b0, 1'b0, 1'b0},
        {2'd0, 16'd80,  2'b10, 1'b0, 1'b0, 1'b0},
        {2'd0, 16'd121, 2'b10, 1'b1, 1'b0, 1'b0},
        {2'd2, 16'd5,   2'b10, 1'b0, 1'b0, 1'b1},
        {2'd2, 16'd70,  2'b10, 1'b0, 1'b1, 1'b1},
        {2'd1, 16'd70,  2'b01, 1'b0, 1'b1, 1'b0},
        {2'd1, 16'd200, 2'b01, 1'b1, 1'b0, 1'b0},
        {2'd0, 16'd4,   2'b01, 1'b0, 1'b0, 1'b1},
        {2'd0, 16'd3,   2'b11, 1'b0, 1'b0, 1'b1},
        {2'd0, 16'd150, 2'b11, 1'b1, 1'b0, 1'b0},
        {2'd3, 16'd6,   2'b01, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Advance n falling edges, accumulating pulse counts.
    task automatic watch(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt_rst += int'(bus_reset);
            cnt_ka  += int'(keep_alive);
        end
    endtask

    // Drive a zero of n cycles, then the ending level, and count pulses.
    task automatic zero_seg(input logic [1:0] m, input int n, input logic [1:0] endp);
        cnt_rst = 0;
        cnt_ka  = 0;
        mode = m;
        {dp, dm} = 2'b00;
        watch(n);
        {dp, dm} = endp;
        watch(8);
    endtask

    initial begin
        rst_n = 1'b0;
        mode  = 2'd0;
        {dp, dm} = 2'b10;
        repeat (3) @(negedge clk);
        check("R10 reset speed auto", int'(speed_low), 0);
        check("R10 reset pulses", int'(bus_reset) + int'(keep_alive), 0);
        mode = 2'd2;
        repeat (2) @(negedge clk);
        check("R10 reset speed forced low", int'(speed_low), 1);
        mode = 2'd0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 first idle full", int'(speed_low), 0);

        for (int v = 0; v < NV; v++) begin
            logic [22:0] e;
            e = VEC[v];
            zero_seg(e[22:21], int'(e[20:5]), e[4:3]);
            check($sformatf("R2 reset pulses vec %0d", v), cnt_rst, int'(e[2]));
            check($sformatf("R3/R4 keep-alive pulses vec %0d", v), cnt_ka, int'(e[1]));
            check($sformatf("R1/R5/R6 speed vec %0d", v), int'(speed_low), int'(e[0]));
        end

        // R7: idle levels, single-ended one and mode change without zero.
        cnt_rst = 0;
        cnt_ka  = 0;
        {dp, dm} = 2'b10;
        watch(5);
        {dp, dm} = 2'b11;
        watch(3);
        {dp, dm} = 2'b10;
        mode = 2'd1;
        watch(6);
        check("R7 speed held without zero", int'(speed_low), 1);
        check("R7 no pulses without zero", cnt_rst + cnt_ka, 0);
        mode = 2'd0;

        // R9: long zero right after reset raises nothing, first idle decides.
        rst_n = 1'b0;
        {dp, dm} = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cnt_rst = 0;
        cnt_ka  = 0;
        watch(130);
        {dp, dm} = 2'b01;
        watch(8);
        check("R9 no reset before first idle", cnt_rst, 0);
        check("R9 no keep-alive before first idle", cnt_ka, 0);
        check("R9 first idle low", int'(speed_low), 1);

        // R8: a keep-alive lasts exactly one cycle at low speed.
        zero_seg(2'd0, 90, 2'b01);
        check("R8 single keep-alive cycle", cnt_ka, 1);
        check("R8 no reset with keep-alive", cnt_rst, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule